// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects interrupt request lines, grouped in banks of 32, and drives two processor request outputs: a normal request (`irq_o`) and a fast request (`fiq_o`). Every line carries its own urgency value, a trigger mode (edge or level) and a routing bit that steers it to one of the two outputs. A per-bank mask hides lines from arbitration. A priority search runs across every bank and names the most urgent eligible line for each output.

Each output is guarded by an acknowledge-style permission flag. When the flag is set and an eligible line exists, the output is raised, the winning line number is captured as that output's vector, and the flag drops. Further requests then leave the output and vector untouched until software writes the control register. That write lowers the output, sets the flag again and starts a new search. Software reads the captured vector to learn the source. A vector read also retires an edge-mode request.

The register port is a simple strobe interface. Read data is combinational. Bits above bit 7 of the address select the bank, and bits 7:0 select the register within the bank.

Top module: `bvic_top`

## Requirements
- R1: After reset all pending bits, trigger modes, routing bits and urgency values are zero. Every mask bit is one. Both outputs are low and both vectors read zero.
- R2: The per-line configuration register of line i is at offset 0x1C+4*i. It holds urgency in bits [6:2], trigger mode in bit 1 (1 = level) and routing in bit 1's neighbour bit 0 (1 = fast output). It reads back in the same layout with all other bits zero, and each bank keeps its own copy.
- R3: An edge-mode line (mode bit 0) sets its pending bit only when its input goes from low to high. An input that stays high does not set the bit again after it has been cleared.
- R4: A level-mode line sets its pending bit while its input is high. The bit clears on the cycle after the input falls.
- R5: A write to the pending register (offset 0x00) ANDs the pending bits with the written data. A level-mode line whose input is high keeps its bit.
- R6: The mask register (offset 0x04) is read/write per bank, and a 1 removes that line from arbitration. A mask write starts a new evaluation of both outputs.
- R7: Among pending, unmasked lines routed to an output, the lowest urgency value wins. On a tie the higher global number (32*bank+bit) wins, and this holds across banks.
- R8: A line with routing bit 0 can only assert `irq_o`. A line with routing bit 1 can only assert `fiq_o`.
- R9: An output rises and its vector is captured only while its permission flag is set. The flag then clears, and later requests change neither the output nor the vector.
- R10: Writing the control register (offset 0x18, bank 0 only) with bit 0 (normal) or bit 1 (fast) set lowers that output, sets its flag and evaluates it again. In any other bank the write has no effect, and the register reads zero.
- R11: Reading offset 0x10 (normal) or 0x14 (fast) in bank 0 returns the winner's bit index within its bank in bits [4:0]. The read clears that line's pending bit if the line is edge-mode, and leaves a level-mode line pending. In other banks these offsets read zero.
- R12: A write to offset 0x9C sets the pending bit of only the lowest set bit of the data, in the addressed bank. The offset reads zero.
- R13: A pending bit shows one clock after its input event is sampled. The output and vector change one clock after the pending latch, mask write or control write that triggered the evaluation.
- R14: A line that latches in the same cycle as a pending-register write or a vector read that would clear it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lines_i | input | NUM_BANKS*32 | Request inputs, bit 32*bank+n |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8+BANK_W | Bank in upper bits, offset in bits 7:0 |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Normal request to the processor |
| fiq_o | output | 1 | Fast request to the processor |

## Verification
The bench focuses on the cycle in which a new request latches on the same clock edge as a software action that would clear the same pending bit. Two cases are covered: a pending-register write of zero, and a vector read that retires an edge-mode line. Each case is provoked by raising the input in the same half-cycle in which the write or read strobe is driven. The pending register is then read back, and the line must still be pending. The permission flag is handled the same way: requests that arrive while the flag is clear must leave the captured vector unchanged.

// File: rtl/bvic_pkg.sv
package bvic_pkg;
  localparam int unsigned LINES_PER_BANK = 32;

  localparam logic [7:0] OFF_PEND    = 8'h00;
  localparam logic [7:0] OFF_MASK    = 8'h04;
  localparam logic [7:0] OFF_VEC_IRQ = 8'h10;
  localparam logic [7:0] OFF_VEC_FIQ = 8'h14;
  localparam logic [7:0] OFF_CTRL    = 8'h18;
  localparam logic [7:0] OFF_CFG0    = 8'h1C;
  localparam logic [7:0] OFF_SWSET   = 8'h9C;

  function automatic logic [LINES_PER_BANK-1:0] lowest_set(input logic [LINES_PER_BANK-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/bvic_bank.sv
module bvic_bank #(
  parameter int unsigned PRIO_W = 5,
  localparam int unsigned LW = bvic_pkg::LINES_PER_BANK,
  localparam int unsigned CW = $clog2(LW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [LW-1:0]        line_i,
  input  logic                 pend_wr_i,
  input  logic                 mask_wr_i,
  input  logic                 cfg_wr_i,
  input  logic                 swset_wr_i,
  input  logic [CW-1:0]        cfg_idx_i,
  input  logic [31:0]          wdata_i,
  input  logic [LW-1:0]        vclr_i,
  output logic [LW-1:0]        pend_o,
  output logic [LW-1:0]        mask_o,
  output logic [LW-1:0]        fast_o,
  output logic [LW*PRIO_W-1:0] prio_o,
  output logic [PRIO_W+1:0]    cfg_rd_o,
  output logic                 latch_o
);
  logic [LW-1:0] in_q, pend_q, mask_q, lvl_q, fast_q;
  logic [PRIO_W-1:0] prio_q [LW];
  logic [LW-1:0] rise_w, fall_w, sw_w, set_w, clr_w, pend_d;

  assign rise_w = line_i & ~in_q;
  assign fall_w = in_q & ~line_i;
  assign sw_w   = swset_wr_i ? bvic_pkg::lowest_set(wdata_i) : '0;
  assign set_w  = (rise_w & ~lvl_q) | (line_i & lvl_q) | sw_w;
  // level lines with input high are shielded from software clear
  assign clr_w  = (pend_wr_i ? ~(wdata_i | (lvl_q & line_i)) : '0)
                | (fall_w & lvl_q)
                | (vclr_i & ~lvl_q);
  // a new latch wins over any clear in the same cycle
  assign pend_d  = (pend_q & ~clr_w) | set_w;
  assign latch_o = |(set_w & ~pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      pend_q <= '0;
      mask_q <= '1;
      lvl_q  <= '0;
      fast_q <= '0;
      for (int i = 0; i < LW; i++) prio_q[i] <= '0;
    end else begin
      in_q   <= line_i;
      pend_q <= pend_d;
      if (mask_wr_i) mask_q <= wdata_i;
      if (cfg_wr_i) begin
        prio_q[cfg_idx_i] <= wdata_i[PRIO_W+1:2];
        lvl_q[cfg_idx_i]  <= wdata_i[1];
        fast_q[cfg_idx_i] <= wdata_i[0];
      end
    end
  end

  for (genvar i = 0; i < LW; i++) begin : g_prio
    assign prio_o[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  assign pend_o   = pend_q;
  assign mask_o   = mask_q;
  assign fast_o   = fast_q;
  assign cfg_rd_o = {prio_q[cfg_idx_i], lvl_q[cfg_idx_i], fast_q[cfg_idx_i]};

  // R3: a rising edge on an edge-mode line is pending next cycle
  a_r3_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(line_i & ~in_q & ~lvl_q) |=>
      ((pend_q & $past(line_i & ~in_q & ~lvl_q)) == $past(line_i & ~in_q & ~lvl_q)));

  // R5: a high level line is pending next cycle whatever software writes
  a_r5_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(line_i & lvl_q) |=> ((pend_q & $past(line_i & lvl_q)) == $past(line_i & lvl_q)));

  // R4: a level line whose input fell is no longer pending
  a_r4_level_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(in_q & ~line_i & lvl_q) && !swset_wr_i && !cfg_wr_i) |=>
      ((pend_q & $past(in_q & ~line_i & lvl_q)) == '0));
endmodule

// File: rtl/bvic_arbiter.sv
module bvic_arbiter #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned PRIO_W    = 5,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]        elig_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  output logic                        any_o,
  output logic [IDX_W-1:0]            win_o
);
  logic [PRIO_W-1:0] best;

  // ascending scan with <= lets the higher line number win ties
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] <= best)) begin
        any_o = 1'b1;
        best  = prio_i[i*PRIO_W +: PRIO_W];
        win_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/bvic_agree.sv
module bvic_agree #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             ctrl_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_i,
  output logic             out_o,
  output logic [IDX_W-1:0] vec_o
);
  logic eval_q, flag_q, out_q;
  logic [IDX_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eval_q <= 1'b0;
      flag_q <= 1'b1;
      out_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      eval_q <= trig_i | ctrl_i;
      if (ctrl_i) begin
        out_q  <= 1'b0;
        flag_q <= 1'b1;
      end else if (eval_q && flag_q && any_i) begin
        out_q  <= 1'b1;
        flag_q <= 1'b0;
        vec_q  <= win_i;
      end
    end
  end

  assign out_o = out_q;
  assign vec_o = vec_q;

  a_r9_raise_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> ($past(flag_q) && !flag_q));

  a_r9_vec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q |=> $stable(vec_q));

  a_r10_ctrl_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i |=> (!out_q && flag_q));
endmodule

// File: rtl/bvic_top.sv
module bvic_top #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned PRIO_W    = 5,
  localparam int unsigned BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned ADDR_W    = 8 + BANK_W,
  localparam int unsigned NUM_LINES = NUM_BANKS * bvic_pkg::LINES_PER_BANK
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic                 irq_o,
  output logic                 fiq_o
);
  import bvic_pkg::*;
  localparam int unsigned LW    = LINES_PER_BANK;
  localparam int unsigned IDX_W = $clog2(NUM_LINES);

  logic [BANK_W-1:0] bank_sel;
  logic [7:0] off, cfg_off;
  logic bank_ok, bank0, wr_en, rd_en, is_cfg, ctrl_wr;
  logic [4:0] cfg_idx;

  assign bank_sel = reg_addr_i[ADDR_W-1:8];
  assign off      = reg_addr_i[7:0];
  assign bank_ok  = 32'(bank_sel) < NUM_BANKS;
  assign bank0    = bank_sel == '0;
  assign wr_en    = reg_req_i & reg_we_i & bank_ok;
  assign rd_en    = reg_req_i & ~reg_we_i & bank_ok;
  assign cfg_off  = off - OFF_CFG0;
  assign is_cfg   = (off >= OFF_CFG0) && (cfg_off[7:2] < 6'd32) && (cfg_off[1:0] == 2'b00);
  assign cfg_idx  = cfg_off[6:2];
  assign ctrl_wr  = wr_en & bank0 & (off == OFF_CTRL);

  logic [1:0] vrd, out_w, any_w;
  logic [IDX_W-1:0] vec_w [2];
  logic [IDX_W-1:0] win_w [2];
  assign vrd[0] = rd_en & bank0 & (off == OFF_VEC_IRQ);
  assign vrd[1] = rd_en & bank0 & (off == OFF_VEC_FIQ);

  logic [NUM_LINES-1:0] vclr;
  always_comb begin
    vclr = '0;
    for (int t = 0; t < 2; t++) if (vrd[t]) vclr[vec_w[t]] = 1'b1;
  end

  logic [LW-1:0] pend_b [NUM_BANKS];
  logic [LW-1:0] mask_b [NUM_BANKS];
  logic [LW-1:0] fast_b [NUM_BANKS];
  logic [PRIO_W+1:0] cfg_b [NUM_BANKS];
  logic [NUM_BANKS-1:0] latch_b, mask_wr_b;
  logic [NUM_LINES-1:0] pend_all, mask_all, fast_all;
  logic [NUM_LINES*PRIO_W-1:0] prio_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel          = wr_en && (bank_sel == BANK_W'(b));
    assign mask_wr_b[b] = sel && (off == OFF_MASK);

    bvic_bank #(.PRIO_W(PRIO_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .line_i    (lines_i[b*LW +: LW]),
      .pend_wr_i (sel && (off == OFF_PEND)),
      .mask_wr_i (mask_wr_b[b]),
      .cfg_wr_i  (sel && is_cfg),
      .swset_wr_i(sel && (off == OFF_SWSET)),
      .cfg_idx_i (cfg_idx),
      .wdata_i   (reg_wdata_i),
      .vclr_i    (vclr[b*LW +: LW]),
      .pend_o    (pend_b[b]),
      .mask_o    (mask_b[b]),
      .fast_o    (fast_b[b]),
      .prio_o    (prio_all[b*LW*PRIO_W +: LW*PRIO_W]),
      .cfg_rd_o  (cfg_b[b]),
      .latch_o   (latch_b[b])
    );

    assign pend_all[b*LW +: LW] = pend_b[b];
    assign mask_all[b*LW +: LW] = mask_b[b];
    assign fast_all[b*LW +: LW] = fast_b[b];
  end

  logic trig;
  assign trig = (|latch_b) | (|mask_wr_b);

  // target 0 = normal output, target 1 = fast output
  for (genvar t = 0; t < 2; t++) begin : g_tgt
    logic [NUM_LINES-1:0] elig;
    assign elig = pend_all & ~mask_all & ((t == 1) ? fast_all : ~fast_all);

    bvic_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_arb (
      .elig_i(elig),
      .prio_i(prio_all),
      .any_o (any_w[t]),
      .win_o (win_w[t])
    );

    bvic_agree #(.IDX_W(IDX_W)) u_agree (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .trig_i(trig),
      .ctrl_i(ctrl_wr & reg_wdata_i[t]),
      .any_i (any_w[t]),
      .win_i (win_w[t]),
      .out_o (out_w[t]),
      .vec_o (vec_w[t])
    );

    // R7: the winner is always an eligible line, and none is named without one
    a_r7_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_w[t] |-> elig[win_w[t]]);
    a_r7_none_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (elig == '0) |-> !any_w[t]);
  end

  assign irq_o = out_w[0];
  assign fiq_o = out_w[1];

  always_comb begin
    reg_rdata_o = '0;
    if (rd_en) begin
      case (off)
        OFF_PEND:    reg_rdata_o = pend_b[bank_sel];
        OFF_MASK:    reg_rdata_o = mask_b[bank_sel];
        OFF_VEC_IRQ: if (bank0) reg_rdata_o = 32'(vec_w[0][4:0]);
        OFF_VEC_FIQ: if (bank0) reg_rdata_o = 32'(vec_w[1][4:0]);
        default:     if (is_cfg) reg_rdata_o = 32'(cfg_b[bank_sel]);
      endcase
    end
  end

  // R8: an output never rises without a pending line on its own route
  a_r8_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fiq_o) |-> $past(|(pend_all & fast_all)));
endmodule

// File: tb/bvic_top_tb_top.sv
module bvic_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] lines = '0;
  logic req = 1'b0, we = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, fiq;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bvic_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  typedef struct packed {
    logic        w;
    logic [8:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  r;
  } step_t;

  // register-port walk: R2 config layout, R6 mask, R10/R11/R12 read-as-zero
  localparam step_t STEPS [15] = '{
    '{1'b1, 9'h030, 32'hFFFF_FFFF, 32'h0,         8'd2},
    '{1'b0, 9'h030, 32'h0,         32'h0000_007F, 8'd2},
    '{1'b1, 9'h124, 32'h0000_000A, 32'h0,         8'd2},
    '{1'b0, 9'h124, 32'h0,         32'h0000_000A, 8'd2},
    '{1'b0, 9'h024, 32'h0,         32'h0,         8'd2},
    '{1'b1, 9'h104, 32'h1234_5678, 32'h0,         8'd6},
    '{1'b0, 9'h104, 32'h0,         32'h1234_5678, 8'd6},
    '{1'b0, 9'h004, 32'h0,         32'hFFFF_FFFF, 8'd6},
    '{1'b0, 9'h018, 32'h0,         32'h0,         8'd10},
    '{1'b0, 9'h110, 32'h0,         32'h0,         8'd11},
    '{1'b0, 9'h09C, 32'h0,         32'h0,         8'd12},
    '{1'b1, 9'h030, 32'h0,         32'h0,         8'd2},
    '{1'b1, 9'h124, 32'h0,         32'h0,         8'd2},
    '{1'b1, 9'h104, 32'hFFFF_FFFF, 32'h0,         8'd6},
    '{1'b0, 9'h030, 32'h0,         32'h0,         8'd2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd(9'h000, v); check("R1 pending b0", v, 32'h0);
    rd(9'h004, v); check("R1 mask b0", v, 32'hFFFF_FFFF);
    rd(9'h104, v); check("R1 mask b1", v, 32'hFFFF_FFFF);
    rd(9'h028, v); check("R1 config line3", v, 32'h0);
    rd(9'h010, v); check("R1 irq vector", v, 32'h0);
    check("R1 outputs low", {30'h0, irq, fiq}, 32'h0);

    for (int i = 0; i < 15; i++) begin
      if (STEPS[i].w) wr(STEPS[i].a, STEPS[i].d);
      else begin
        rd(STEPS[i].a, v);
        check($sformatf("R%0d table step %0d", STEPS[i].r, i), v, STEPS[i].e);
      end
    end

    wr(9'h004, 32'h0);
    cyc(1);

    // R3 / R13 / R9 / R11 edge line, latency, vector read clear
    lines[4] = 1'b1;
    cyc(1);
    check("R13 output not yet raised", {31'h0, irq}, 32'h0);
    rd(9'h000, v); check("R3 edge latched", v, 32'h10);
    check("R9 irq raised", {31'h0, irq}, 32'h1);
    rd(9'h010, v); check("R11 vector index", v, 32'd4);
    cyc(2);
    rd(9'h000, v); check("R3 held high no relatch", v, 32'h0);
    lines[4] = 1'b0;
    wr(9'h118, 32'h1);
    check("R10 bank1 control ignored", {31'h0, irq}, 32'h1);
    wr(9'h018, 32'h1);
    check("R10 control drops irq", {31'h0, irq}, 32'h0);
    cyc(1);
    check("R10 nothing eligible stays low", {31'h0, irq}, 32'h0);

    // R7 tie and R9 flag hold
    lines[7] = 1'b1; lines[9] = 1'b1;
    cyc(2);
    rd(9'h010, v); check("R7 tie higher number", v, 32'd9);
    lines[1] = 1'b1;
    cyc(2);
    rd(9'h010, v); check("R9 vector held while flag clear", v, 32'd9);
    rd(9'h000, v); check("R9 later requests pending", v, 32'h82);
    lines[7] = 1'b0; lines[9] = 1'b0; lines[1] = 1'b0;
    wr(9'h018, 32'h1);
    cyc(1);
    rd(9'h010, v); check("R10 re-evaluation picks 7", v, 32'd7);
    wr(9'h018, 32'h1);
    cyc(1);
    rd(9'h010, v); check("R10 re-evaluation picks 1", v, 32'd1);
    wr(9'h018, 32'h1);
    cyc(1);
    check("R10 idle after drain", {31'h0, irq}, 32'h0);

    // R7 across banks
    wr(9'h06C, 32'h4);
    wr(9'h128, 32'h8);
    wr(9'h104, 32'h0);
    lines[20] = 1'b1; lines[35] = 1'b1;
    cyc(2);
    rd(9'h010, v); check("R7 lower value wins", v, 32'd20);
    wr(9'h018, 32'h1);
    cyc(1);
    rd(9'h010, v); check("R11 index within bank 1", v, 32'd3);
    lines[20] = 1'b0; lines[35] = 1'b0;
    wr(9'h104, 32'hFFFF_FFFF);
    wr(9'h018, 32'h1);
    cyc(1);
    rd(9'h100, v); check("R11 bank1 line cleared", v, 32'h0);

    // R8 routing to fast output
    wr(9'h04C, 32'h1);
    lines[12] = 1'b1;
    cyc(2);
    check("R8 fast output", {30'h0, irq, fiq}, 32'h1);
    rd(9'h014, v); check("R8 fast vector", v, 32'd12);
    lines[12] = 1'b0;
    wr(9'h018, 32'h2);
    cyc(1);
    check("R10 fast dropped", {31'h0, fiq}, 32'h0);

    // R4 / R5 level line
    wr(9'h034, 32'h2);
    lines[6] = 1'b1;
    cyc(2);
    wr(9'h000, 32'h0);
    rd(9'h000, v); check("R5 level high not cleared", v, 32'h40);
    rd(9'h010, v); check("R11 level vector", v, 32'd6);
    rd(9'h000, v); check("R11 level stays pending", v, 32'h40);
    lines[6] = 1'b0;
    cyc(1);
    rd(9'h000, v); check("R4 level drop clears", v, 32'h0);
    wr(9'h018, 32'h1);
    cyc(1);
    lines[2] = 1'b1;
    cyc(1);
    lines[2] = 1'b0;
    cyc(1);
    wr(9'h000, 32'hFFFF_FFFB);
    rd(9'h000, v); check("R5 edge bit cleared by AND", v, 32'h0);
    wr(9'h018, 32'h1);
    cyc(1);

    // R6 mask hides, mask write re-evaluates
    wr(9'h004, 32'h100);
    lines[8] = 1'b1;
    cyc(2);
    check("R6 masked line no output", {31'h0, irq}, 32'h0);
    rd(9'h000, v); check("R6 masked line pending", v, 32'h100);
    lines[8] = 1'b0;
    wr(9'h004, 32'h0);
    cyc(1);
    check("R6 unmask raises", {31'h0, irq}, 32'h1);
    rd(9'h010, v); check("R6 vector after unmask", v, 32'd8);
    wr(9'h018, 32'h1);
    cyc(1);

    // R12 software set
    wr(9'h19C, 32'h50);
    rd(9'h100, v); check("R12 lowest bit only", v, 32'h10);
    rd(9'h000, v); check("R12 other bank untouched", v, 32'h0);
    wr(9'h100, 32'h0);
    rd(9'h100, v); check("R12 cleared", v, 32'h0);

    // R14 same-cycle latch and clear
    lines[10] = 1'b1;
    wr(9'h000, 32'h0);
    rd(9'h000, v); check("R14 latch beats pending write", v, 32'h400);
    check("R14 irq raised", {31'h0, irq}, 32'h1);
    lines[10] = 1'b0;
    cyc(1);
    lines[10] = 1'b1;
    rd(9'h010, v); check("R14 vector", v, 32'd10);
    rd(9'h000, v); check("R14 latch beats vector read", v, 32'h400);
    lines[10] = 1'b0;
    wr(9'h000, 32'h0);
    rd(9'h000, v); check("R5 final clear", v, 32'h0);
    wr(9'h018, 32'h1);
    cyc(1);
    check("R10 final idle", {30'h0, irq, fiq}, 32'h0);

    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule